// File: doc/BRIEF.md
# Two-Stage Clock Divider Pair Search

This block picks the divider settings for a clock path built from two dividers in series: a power-of-two stage P (1, 2, 4, ...) and a linear stage M (1, 2, 3, ...). It receives a source frequency, a wanted frequency and an upper bound for each divider. It then tries every legal (P, M) pair and keeps the one whose output frequency is nearest to the wanted frequency without going above it.

A request is a one-cycle `start` pulse with the operands on the input ports. The engine runs while `busy` is high and raises `done` for one cycle when it finishes. It reports the chosen P and M, their register field codes and the frequency they produce. Each candidate takes a bit-serial division, so a request takes roughly `(FREQ_W + 2)` cycles per pair tried.

Top module: `divpair_search`

## Requirements
- R1: A `start` pulse taken while idle makes `busy` high on the next cycle. A `start` pulse while `busy` is high is ignored, and that run's results come from the operands of the accepted pulse.
- R2: P takes the values 1, 2, 4, ... while P is no larger than the P bound. For each P, M takes every value from 1 up to and including the M bound. P is the outer loop.
- R3: A candidate frequency is `floor(floor(parent / P) / M)`.
- R4: A candidate above the target is never chosen, so `best_freq` never exceeds the target.
- R5: A candidate replaces the held best only when its distance below the target is strictly smaller. On a tie the pair found first is kept: smaller P first, then smaller M within the same P.
- R6: An M bound of 0 selects 2^M_W. A P bound of 0 selects 2^(2^P_W − 1). With the defaults these are 16 and 8.
- R7: `m_code` equals M − M_OFFSET (M_OFFSET defaults to 1), truncated to M_W bits. `p_code` equals log2(P).
- R8: If no candidate qualifies, `best_m`, `best_p`, `m_code`, `p_code` and `best_freq` are all zero. A target of 0 gives this result.
- R9: `done` is high for exactly one cycle per accepted start. The result outputs keep their values from `done` until the next accepted start.
- R10: After reset, `busy`, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| parent_freq | input | FREQ_W | Source frequency |
| target_freq | input | FREQ_W | Wanted frequency |
| m_limit | input | M_W+1 | Largest M; 0 selects the default |
| p_limit | input | 2^P_W | Largest P; 0 selects the default |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_m | output | M_W+1 | Chosen M, 0 if none |
| best_p | output | 2^P_W | Chosen P, 0 if none |
| m_code | output | M_W | Field code for M |
| p_code | output | P_W | Field code for P |
| best_freq | output | FREQ_W | Frequency of the chosen pair |

## Verification
The assertions assume that `p_limit` stays below 2^(2^P_W), so that the P register never has to hold a value past its width. They also assume that operands only matter on the cycle `start` is taken, since the engine latches them then. The stimulus therefore uses default or small explicit P bounds. It changes the operand ports freely while the engine is busy or idle, which shows that only the latched copies steer the search. The tie cases use targets that several pairs hit exactly, so the first-found rule is exercised rather than assumed.

// File: rtl/divpair_search.sv
module divpair_search #(
  parameter int FREQ_W   = 32,
  parameter int M_W      = 4,
  parameter int P_W      = 2,
  parameter int M_OFFSET = 1,
  localparam int MC_W    = M_W + 1,
  localparam int PV_W    = 2 ** P_W,
  localparam int CNT_W   = $clog2(FREQ_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] parent_freq,
  input  logic [FREQ_W-1:0] target_freq,
  input  logic [MC_W-1:0]   m_limit,
  input  logic [PV_W-1:0]   p_limit,
  output logic              busy,
  output logic              done,
  output logic [MC_W-1:0]   best_m,
  output logic [PV_W-1:0]   best_p,
  output logic [M_W-1:0]    m_code,
  output logic [P_W-1:0]    p_code,
  output logic [FREQ_W-1:0] best_freq
);

  localparam logic [MC_W-1:0] M_DEF = MC_W'(1) << M_W;
  localparam logic [PV_W-1:0] P_DEF = PV_W'(1) << (PV_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_DIV, S_EVAL, S_DONE} state_t;
  state_t state;

  logic [FREQ_W-1:0] parent_q, tgt_q, dvd, rem;
  logic [MC_W-1:0]   m_q, m_lim_q;
  logic [PV_W-1:0]   p_q, p_lim_q;
  logic [P_W-1:0]    plog;
  logic [CNT_W-1:0]  cnt;

  logic [FREQ_W:0]   rem_sh;
  logic              sub_ok;
  logic              hit, last_m, more_p;
  logic [PV_W:0]     p_nxt;

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign rem_sh = {rem, dvd[FREQ_W-1]};
  assign sub_ok = rem_sh >= (FREQ_W+1)'(m_q);
  assign hit    = (dvd <= tgt_q) && ((tgt_q - dvd) < (tgt_q - best_freq));
  assign last_m = (m_q >= m_lim_q);
  assign p_nxt  = {1'b0, p_q} << 1;
  assign more_p = (p_nxt <= {1'b0, p_lim_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      parent_q  <= '0;
      tgt_q     <= '0;
      m_lim_q   <= '0;
      p_lim_q   <= '0;
      m_q       <= MC_W'(1);
      p_q       <= PV_W'(1);
      plog      <= '0;
      dvd       <= '0;
      rem       <= '0;
      cnt       <= '0;
      best_m    <= '0;
      best_p    <= '0;
      m_code    <= '0;
      p_code    <= '0;
      best_freq <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          parent_q  <= parent_freq;
          tgt_q     <= target_freq;
          m_lim_q   <= (m_limit == '0) ? M_DEF : m_limit;
          p_lim_q   <= (p_limit == '0) ? P_DEF : p_limit;
          m_q       <= MC_W'(1);
          p_q       <= PV_W'(1);
          plog      <= '0;
          best_m    <= '0;
          best_p    <= '0;
          m_code    <= '0;
          p_code    <= '0;
          best_freq <= '0;
          state     <= S_SETUP;
        end
        S_SETUP: begin
          dvd   <= parent_q >> plog;
          rem   <= '0;
          cnt   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          rem   <= sub_ok ? FREQ_W'(rem_sh - (FREQ_W+1)'(m_q)) : rem_sh[FREQ_W-1:0];
          dvd   <= {dvd[FREQ_W-2:0], sub_ok};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(FREQ_W - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (hit) begin
            best_freq <= dvd;
            best_m    <= m_q;
            best_p    <= p_q;
            m_code    <= M_W'(m_q - MC_W'(M_OFFSET));
            p_code    <= plog;
          end
          if (!last_m) begin
            m_q   <= m_q + 1'b1;
            state <= S_SETUP;
          end else if (more_p) begin
            m_q   <= MC_W'(1);
            p_q   <= p_nxt[PV_W-1:0];
            plog  <= plog + 1'b1;
            state <= S_SETUP;
          end else begin
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(tgt_q) && $stable(parent_q) && $stable(m_lim_q)));

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R2
  p_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(p_q) == 1 && p_q <= p_lim_q));

  // R2
  m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (m_q >= MC_W'(1) && m_q <= m_lim_q));

  logic [FREQ_W+MC_W-1:0] chk_prod, chk_num;
  assign chk_prod = (FREQ_W+MC_W)'(dvd) * (FREQ_W+MC_W)'(m_q);
  assign chk_num  = (FREQ_W+MC_W)'(parent_q >> plog);

  // R3
  quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL) |-> (chk_prod <= chk_num &&
                           (chk_num - chk_prod) < (FREQ_W+MC_W)'(m_q)));

  // R4
  best_le_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_freq <= tgt_q);

  // R5
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL) |=> best_freq >= $past(best_freq));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(best_freq) && $stable(best_m) && $stable(best_p)));

endmodule

// File: tb/divpair_search_tb_top.sv
module divpair_search_tb_top;
  localparam int FREQ_W = 32, M_W = 4, P_W = 2, M_OFFSET = 1;
  localparam int MC_W = M_W + 1, PV_W = 2 ** P_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [FREQ_W-1:0] parent_freq = '0, target_freq = '0;
  logic [MC_W-1:0] m_limit = '0;
  logic [PV_W-1:0] p_limit = '0;
  logic busy, done;
  logic [MC_W-1:0] best_m;
  logic [PV_W-1:0] best_p;
  logic [M_W-1:0] m_code;
  logic [P_W-1:0] p_code;
  logic [FREQ_W-1:0] best_freq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  divpair_search #(.FREQ_W(FREQ_W), .M_W(M_W), .P_W(P_W), .M_OFFSET(M_OFFSET)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .parent_freq(parent_freq),
    .target_freq(target_freq), .m_limit(m_limit), .p_limit(p_limit),
    .busy(busy), .done(done), .best_m(best_m), .best_p(best_p),
    .m_code(m_code), .p_code(p_code), .best_freq(best_freq));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic golden(input longint par, input longint tgt, input longint ml, input longint pl,
                        output longint em, output longint ep, output longint ef,
                        output longint emc, output longint epc);
    longint mlim, plim, lg;
    mlim = (ml == 0) ? (1 << M_W) : ml;
    plim = (pl == 0) ? (1 << (PV_W - 1)) : pl;
    em = 0; ep = 0; ef = 0; emc = 0; epc = 0; lg = 0;
    for (longint p = 1; p <= plim; p = p * 2) begin
      for (longint m = 1; m <= mlim; m++) begin
        longint c;
        c = (par / p) / m;
        if (c <= tgt && (tgt - c) < (tgt - ef)) begin
          ef = c; em = m; ep = p; emc = (m - M_OFFSET) & ((1 << M_W) - 1); epc = lg;
        end
      end
      lg++;
    end
  endtask

  task automatic pulse_start(input longint par, input longint tgt, input longint ml, input longint pl);
    @(negedge clk);
    parent_freq = FREQ_W'(par); target_freq = FREQ_W'(tgt);
    m_limit = MC_W'(ml); p_limit = PV_W'(pl);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check({req, " done timeout"}, 0, 1);
  endtask

  task automatic expect_result(input string req, input longint par, input longint tgt,
                               input longint ml, input longint pl);
    longint em, ep, ef, emc, epc;
    golden(par, tgt, ml, pl, em, ep, ef, emc, epc);
    check({req, " best_m"}, best_m, em);
    check({req, " best_p"}, best_p, ep);
    check({req, " best_freq"}, best_freq, ef);
    check("R7 m_code", m_code, emc);
    check("R7 p_code", p_code, epc);
  endtask

  task automatic run_case(input string req, input longint par, input longint tgt,
                          input longint ml, input longint pl);
    pulse_start(par, tgt, ml, pl);
    check("R1 busy after start", busy, 1);
    wait_done(req);
    expect_result(req, par, tgt, ml, pl);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 best_m", best_m, 0);
    check("R10 best_p", best_p, 0);
    check("R10 best_freq", best_freq, 0);
    check("R10 codes", {m_code, p_code}, 0);
  endtask

  task automatic t_tie();
    run_case("R5 tie first pair", 24000000, 1000000, 0, 0);
    check("R5 tie m", best_m, 12);
    check("R5 tie p", best_p, 2);
    check("R7 tie m_code", m_code, 11);
    check("R7 tie p_code", p_code, 1);
  endtask

  task automatic t_above_parent();
    run_case("R4 target above parent", 1000, 5000, 0, 0);
    check("R4 undivided", best_freq, 1000);
  endtask

  task automatic t_none();
    run_case("R8 nothing qualifies", 1000, 10, 4, 2);
    check("R8 zero freq", best_freq, 0);
    check("R8 zero m", best_m, 0);
    run_case("R8 zero target", 5000, 0, 0, 0);
    check("R8 zero p", best_p, 0);
  endtask

  task automatic t_limits();
    run_case("R2 explicit limits", 100, 33, 5, 1);
    check("R2 m three", best_m, 3);
    run_case("R6 default limits", 1000, 7, 0, 0);
    check("R6 p reaches 8", best_p, 8);
    run_case("R2 p bound not power of two", 96000, 1100, 3, 7);
  endtask

  task automatic t_trunc();
    run_case("R3 truncation", 100, 14, 0, 0);
    run_case("R3 odd parent", 99999, 4321, 0, 0);
    run_case("R3 large parent", 32'hFFFF_FFF1, 32'h0123_4567, 15, 0);
    run_case("R4 below every exact", 7777, 500, 9, 4);
  endtask

  task automatic t_busy_ignore();
    pulse_start(48000, 2999, 0, 0);
    repeat (5) @(negedge clk);
    start = 1; parent_freq = 12345; target_freq = 77; m_limit = 2; p_limit = 1;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done("R1 ignored start");
    expect_result("R1 ignored start", 48000, 2999, 0, 0);
  endtask

  task automatic t_hold();
    longint f, m, p;
    run_case("R9 hold", 3000000, 123456, 0, 0);
    f = best_freq; m = best_m; p = best_p;
    parent_freq = 1; target_freq = 1; m_limit = 1; p_limit = 1;
    repeat (20) @(negedge clk);
    check("R9 freq held", best_freq, f);
    check("R9 m held", best_m, m);
    check("R9 p held", best_p, p);
    check("R9 idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tie();
    t_above_parent();
    t_none();
    t_limits();
    t_trunc();
    t_busy_ignore();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule